// File: doc/BRIEF.md
# Board Control and Status Register File

This block is the board-level register file that sits on chip select 0 of a card's 16-bit local bus. It holds a read-only species code and a writable interrupter Status/ID word, and it keeps a control/status word. That word gathers the output-enable controls, the driver and scan-controller enables, the global interrupt enable, two sticky event flags and several live status bits. Two 32-bit per-chip masks sit beside it, one selecting chips for configuration and one enabling interrupts, and each is split over two 16-bit words. Three read-only 32-bit views show the configured-done lines, the raw active-low status lines and the per-chip interrupt requests. The block also provides sixteen words of scratch storage.

A local-bus access is one cycle of `bus_req` with `bus_wr` and a 5-bit word offset. Read data appears on `bus_rdata` on the clock edge after the read cycle and holds until the next read. The control bits drive the board enables directly. Bits 2 and 3 are inverted because their outputs are active low. Configuration writes must first be armed: software writes the arm bit (control bit 0) as 0, then 1, then 0. After that, each configuration-write strobe selects every chip whose configuration-enable bit is set, except chip 0.

Top module: `brd_regfile`

## Requirements
- R1: After reset, `bus_rdata` from offset 2 reads 0x0380 when `jtag_rdy_n`=1, `cfg_err_n`=1 and `irq_live`=0. Bits 8 and 9 are 1 and every writable control bit is 0. The outputs are `arr_oe_n`=1, `sup_oe_n`=1, `gie`=0, `status_id`=0 and `cfg_sel`=0.
- R2: A read returns data on `bus_rdata` one clock after the read cycle. Offset 0 returns the SPECIES parameter. Offsets 3, 14 and 15 return 0.
- R3: These words read back what was last written: offset 1 (the Status/ID word, also driven on `status_id`), offsets 4/5 (configuration enables, low/high chips), offsets 8/9 (interrupt enables, low/high chips) and offsets 16–31 (scratch).
- R4: Writes to the read-only words are ignored, and those words keep showing their sources. The read-only words are offset 0, offsets 6/7 (`chip_done` low/high), offsets 10/11 (`chip_stat_n` low/high) and offsets 12/13 (interrupt requests).
- R5: Control bit 2 drives `arr_oe_n` and bit 3 drives `sup_oe_n`, both inverted. Bits 4, 5 and 6 drive `ecl_en`, `jtag_en` and `jtag_tla` directly. Each output takes its new value one clock after the write.
- R6: Control bit 9 is set by a `bus_err_pls` cycle. Writing 0 clears bit 8 or bit 9, and writing 1 leaves them unchanged. An error pulse in the same cycle as a write that clears bit 9 leaves bit 9 at 1. Only reset sets bit 8.
- R7: A cycle of `irq_ack_pls` clears control bit 1 (`gie`), and this wins over a write of 1 to that bit in the same cycle.
- R8: Offsets 12/13 read the interrupt-enable mask AND NOT `chip_stat_n`. Control bit 10 is the OR of those bits, whatever the value of `gie`. `irq_raise` becomes `gie` AND bit 10 one clock later.
- R9: Control bit 7 reads `jtag_rdy_n`, bit 11 reads NOT `cfg_err_n` and bit 12 reads `irq_live`. Bits 15–13 read 0. Writes to bits 7 and 10–15 have no effect.
- R10: Once bit 0 has been written 0, then 1, then 0, a `cfg_wr` cycle makes `cfg_sel` equal to the configuration-enable mask with bit 0 forced to 0, on the next clock and for one clock. When not armed, `cfg_sel` stays 0.
- R11: Any of the following drops the armed state or breaks the sequence: writing 1 to bit 0 while armed, a write with any 1 bit to offset 4 or 5, or a second 1 in place of the closing 0. An all-zero write to offset 4 or 5 keeps the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Local-bus access cycle for chip select 0 |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid one clock after the read |
| chip_stat_n | input | 2*DW | Per-chip status lines, active low |
| chip_done | input | 2*DW | Per-chip configured lines |
| jtag_rdy_n | input | 1 | Scan controller ready, active low |
| cfg_err_n | input | 1 | Configuration error, active low |
| irq_live | input | 1 | Interrupter currently requesting |
| bus_err_pls | input | 1 | Slave bus-error event |
| irq_ack_pls | input | 1 | Interrupter acknowledge, disables interrupts |
| cfg_wr | input | 1 | Write to the configuration address |
| status_id | output | DW | Interrupter Status/ID word |
| gie | output | 1 | Global interrupt enable |
| arr_oe_n | output | 1 | Array output enable, active low |
| sup_oe_n | output | 1 | Support output enable, active low |
| ecl_en | output | 1 | ECL driver enable |
| jtag_en | output | 1 | Scan controller enable |
| jtag_tla | output | 1 | Scan test-logic activate |
| irq_raise | output | 1 | Interrupt request toward the interrupter |
| cfg_sel | output | 2*DW | Per-chip configuration-write selects |

## Verification
Two functions can land on the same bit in the same cycle. A software write to the control word can coincide with the hardware event that owns that bit: a bus-error pulse against a write that clears the error flag, or an acknowledge pulse against a write that sets the global interrupt enable. The bench drives the write and the pulse in the same cycle. It then judges the result from the flag read back at offset 2 and from the `gie` and `irq_raise` pins, and in both cases the hardware event must win.

// File: rtl/brd_pkg.sv
package brd_pkg;
  // word offsets on chip select 0
  localparam int OFS_SPECIES = 0;
  localparam int OFS_STATID  = 1;
  localparam int OFS_CSR     = 2;
  localparam int OFS_CEN_LO  = 4;
  localparam int OFS_CEN_HI  = 5;
  localparam int OFS_DONE_LO = 6;
  localparam int OFS_DONE_HI = 7;
  localparam int OFS_IE_LO   = 8;
  localparam int OFS_IE_HI   = 9;
  localparam int OFS_STAT_LO = 10;
  localparam int OFS_STAT_HI = 11;
  localparam int OFS_REQ_LO  = 12;
  localparam int OFS_REQ_HI  = 13;
  localparam int OFS_SCR     = 16;

  // control word bit positions
  localparam int CB_ARM   = 0;
  localparam int CB_GIE   = 1;
  localparam int CB_AOE   = 2;
  localparam int CB_SOE   = 3;
  localparam int CB_ECL   = 4;
  localparam int CB_JEN   = 5;
  localparam int CB_JTLA  = 6;
  localparam int CB_JRDY  = 7;
  localparam int CB_RECFG = 8;
  localparam int CB_BERR  = 9;
  localparam int CB_REQ   = 10;
  localparam int CB_CERR  = 11;
  localparam int CB_IRQ   = 12;
  localparam int CTL_W    = 7;   // writable plain control bits 6:0

  typedef enum logic [1:0] {
    ARM_IDLE,
    ARM_ZERO,
    ARM_ONE,
    ARM_SET
  } arm_st_e;
endpackage

// File: rtl/brd_arm_seq.sv
module brd_arm_seq
  import brd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic csr_wr,
  input  logic arm_bit,
  input  logic cen_ones,
  output logic armed
);
  arm_st_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ARM_IDLE;
    end else if (cen_ones) begin
      st_q <= ARM_IDLE;
    end else if (csr_wr) begin
      case (st_q)
        ARM_IDLE: st_q <= arm_bit ? ARM_IDLE : ARM_ZERO;
        ARM_ZERO: st_q <= arm_bit ? ARM_ONE  : ARM_ZERO;
        ARM_ONE:  st_q <= arm_bit ? ARM_IDLE : ARM_SET;
        default:  st_q <= arm_bit ? ARM_IDLE : ARM_SET;
      endcase
    end
  end

  assign armed = (st_q == ARM_SET);
endmodule

// File: rtl/brd_ctrl_csr.sv
module brd_ctrl_csr
  import brd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] ctl_wd,
  input  logic             recfg_wd,
  input  logic             berr_wd,
  input  logic             berr_pls,
  input  logic             ack_pls,
  output logic [CTL_W-1:0] ctl,
  output logic             recfg,
  output logic             berr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= '0;
      recfg <= 1'b1;
      berr  <= 1'b1;
    end else begin
      if (wr) begin
        ctl   <= ctl_wd;
        recfg <= recfg & recfg_wd;   // write 0 clears, write 1 keeps
        berr  <= berr & berr_wd;
      end
      // hardware events take priority over a same-cycle write
      if (ack_pls)  ctl[CB_GIE] <= 1'b0;
      if (berr_pls) berr        <= 1'b1;
    end
  end
endmodule

// File: rtl/brd_scratch.sv
module brd_scratch #(
  parameter int DW    = 16,
  parameter int WORDS = 16,
  localparam int SAW  = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [SAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic           re,
  input  logic [SAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/brd_regfile.sv
module brd_regfile
  import brd_pkg::*;
#(
  parameter int          DW        = 16,
  parameter int          AW        = 5,
  parameter int          SCR_WORDS = 16,
  parameter logic [15:0] SPECIES   = 16'h0A5C,
  localparam int         NCHIP     = 2 * DW,
  localparam int         SAW       = $clog2(SCR_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_req,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NCHIP-1:0] chip_stat_n,
  input  logic [NCHIP-1:0] chip_done,
  input  logic             jtag_rdy_n,
  input  logic             cfg_err_n,
  input  logic             irq_live,
  input  logic             bus_err_pls,
  input  logic             irq_ack_pls,
  input  logic             cfg_wr,
  output logic [DW-1:0]    status_id,
  output logic             gie,
  output logic             arr_oe_n,
  output logic             sup_oe_n,
  output logic             ecl_en,
  output logic             jtag_en,
  output logic             jtag_tla,
  output logic             irq_raise,
  output logic [NCHIP-1:0] cfg_sel
);
  logic             wr_stb, rd_stb, scr_hit, csr_wr, cen_ones, armed;
  logic [NCHIP-1:0] cen_q, ie_q, req_vec;
  logic             any_req;
  logic [CTL_W-1:0] ctl;
  logic             csr_recfg, csr_berr;
  logic [DW-1:0]    csr_word, rd_word, mux_q, scr_q;
  logic             scr_sel_q;

  assign wr_stb  = bus_req & bus_wr;
  assign rd_stb  = bus_req & ~bus_wr;
  assign scr_hit = (int'(bus_addr) >= OFS_SCR) && (int'(bus_addr) < OFS_SCR + SCR_WORDS);
  assign csr_wr  = wr_stb && (bus_addr == AW'(OFS_CSR));
  assign cen_ones = wr_stb && (|bus_wdata) &&
                    ((bus_addr == AW'(OFS_CEN_LO)) || (bus_addr == AW'(OFS_CEN_HI)));

  // Status/ID word
  always_ff @(posedge clk) begin
    if (rst)                                       status_id <= '0;
    else if (wr_stb && bus_addr == AW'(OFS_STATID)) status_id <= bus_wdata;
  end

  // per-chip masks, two halves each
  always_ff @(posedge clk) begin
    if (rst) begin
      cen_q <= '0;
      ie_q  <= '0;
    end else begin
      for (int h = 0; h < 2; h++) begin
        if (wr_stb && bus_addr == AW'(OFS_CEN_LO + h)) cen_q[h*DW +: DW] <= bus_wdata;
        if (wr_stb && bus_addr == AW'(OFS_IE_LO + h))  ie_q[h*DW +: DW]  <= bus_wdata;
      end
    end
  end

  assign req_vec = ie_q & ~chip_stat_n;
  assign any_req = |req_vec;

  brd_ctrl_csr u_csr (
    .clk      (clk),
    .rst      (rst),
    .wr       (csr_wr),
    .ctl_wd   (bus_wdata[CTL_W-1:0]),
    .recfg_wd (bus_wdata[CB_RECFG]),
    .berr_wd  (bus_wdata[CB_BERR]),
    .berr_pls (bus_err_pls),
    .ack_pls  (irq_ack_pls),
    .ctl      (ctl),
    .recfg    (csr_recfg),
    .berr     (csr_berr)
  );

  brd_arm_seq u_arm (
    .clk      (clk),
    .rst      (rst),
    .csr_wr   (csr_wr),
    .arm_bit  (bus_wdata[CB_ARM]),
    .cen_ones (cen_ones),
    .armed    (armed)
  );

  brd_scratch #(.DW(DW), .WORDS(SCR_WORDS)) u_scr (
    .clk   (clk),
    .we    (wr_stb & scr_hit),
    .waddr (bus_addr[SAW-1:0]),
    .wdata (bus_wdata),
    .re    (rd_stb & scr_hit),
    .raddr (bus_addr[SAW-1:0]),
    .rdata (scr_q)
  );

  assign gie      = ctl[CB_GIE];
  assign arr_oe_n = ~ctl[CB_AOE];
  assign sup_oe_n = ~ctl[CB_SOE];
  assign ecl_en   = ctl[CB_ECL];
  assign jtag_en  = ctl[CB_JEN];
  assign jtag_tla = ctl[CB_JTLA];

  always_comb begin
    csr_word              = '0;
    csr_word[CTL_W-1:0]   = ctl;
    csr_word[CB_JRDY]     = jtag_rdy_n;
    csr_word[CB_RECFG]    = csr_recfg;
    csr_word[CB_BERR]     = csr_berr;
    csr_word[CB_REQ]      = any_req;
    csr_word[CB_CERR]     = ~cfg_err_n;
    csr_word[CB_IRQ]      = irq_live;
  end

  always_comb begin
    case (bus_addr)
      AW'(OFS_SPECIES): rd_word = DW'(SPECIES);
      AW'(OFS_STATID):  rd_word = status_id;
      AW'(OFS_CSR):     rd_word = csr_word;
      AW'(OFS_CEN_LO):  rd_word = cen_q[DW-1:0];
      AW'(OFS_CEN_HI):  rd_word = cen_q[NCHIP-1:DW];
      AW'(OFS_DONE_LO): rd_word = chip_done[DW-1:0];
      AW'(OFS_DONE_HI): rd_word = chip_done[NCHIP-1:DW];
      AW'(OFS_IE_LO):   rd_word = ie_q[DW-1:0];
      AW'(OFS_IE_HI):   rd_word = ie_q[NCHIP-1:DW];
      AW'(OFS_STAT_LO): rd_word = chip_stat_n[DW-1:0];
      AW'(OFS_STAT_HI): rd_word = chip_stat_n[NCHIP-1:DW];
      AW'(OFS_REQ_LO):  rd_word = req_vec[DW-1:0];
      AW'(OFS_REQ_HI):  rd_word = req_vec[NCHIP-1:DW];
      default:          rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mux_q     <= '0;
      scr_sel_q <= 1'b0;
    end else if (rd_stb) begin
      mux_q     <= rd_word;
      scr_sel_q <= scr_hit;
    end
  end

  assign bus_rdata = scr_sel_q ? scr_q : mux_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_sel   <= '0;
      irq_raise <= 1'b0;
    end else begin
      cfg_sel   <= (armed && cfg_wr) ? (cen_q & ~NCHIP'(1)) : '0;
      irq_raise <= gie & any_req;
    end
  end
endmodule

// File: rtl/brd_regfile_chk.sv
module brd_regfile_chk #(
  parameter int  DW    = 16,
  parameter int  AW    = 5,
  localparam int NCHIP = 2 * DW
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_req,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic             irq_ack_pls,
  input logic             bus_err_pls,
  input logic             cfg_wr,
  input logic             gie,
  input logic             arr_oe_n,
  input logic             sup_oe_n,
  input logic             irq_raise,
  input logic [NCHIP-1:0] cfg_sel,
  input logic             armed,
  input logic             csr_berr,
  input logic             csr_recfg
);
  p_oe_inverted_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_wr && bus_addr == AW'(2)) |=>
      (arr_oe_n == !$past(bus_wdata[2])) && (sup_oe_n == !$past(bus_wdata[3])));

  p_berr_set_r6: assert property (@(posedge clk) disable iff (rst)
    bus_err_pls |=> csr_berr);

  p_recfg_stays_clear_r6: assert property (@(posedge clk) disable iff (rst)
    !csr_recfg |=> !csr_recfg);

  p_ack_drops_gie_r7: assert property (@(posedge clk) disable iff (rst)
    irq_ack_pls |=> !gie);

  p_raise_needs_gie_r8: assert property (@(posedge clk) disable iff (rst)
    irq_raise |-> $past(gie));

  p_sel_needs_arm_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_sel != '0) |-> ($past(cfg_wr) && $past(armed)));
endmodule

bind brd_regfile brd_regfile_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_req     (bus_req),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .irq_ack_pls (irq_ack_pls),
  .bus_err_pls (bus_err_pls),
  .cfg_wr      (cfg_wr),
  .gie         (gie),
  .arr_oe_n    (arr_oe_n),
  .sup_oe_n    (sup_oe_n),
  .irq_raise   (irq_raise),
  .cfg_sel     (cfg_sel),
  .armed       (armed),
  .csr_berr    (csr_berr),
  .csr_recfg   (csr_recfg)
);

// File: tb/brd_regfile_bench.sv
`timescale 1ns/1ps
module brd_regfile_bench;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam logic [15:0] SPEC = 16'h0A5C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_req = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [31:0]   chip_stat_n = '1;
  logic [31:0]   chip_done = 32'h0003_8001;
  logic          jtag_rdy_n = 1, cfg_err_n = 1, irq_live = 0;
  logic          bus_err_pls = 0, irq_ack_pls = 0, cfg_wr = 0;
  logic [DW-1:0] status_id;
  logic          gie, arr_oe_n, sup_oe_n, ecl_en, jtag_en, jtag_tla, irq_raise;
  logic [31:0]   cfg_sel;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  brd_regfile #(.DW(DW), .AW(AW), .SPECIES(SPEC)) u_brd_regfile (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chip_stat_n(chip_stat_n),
    .chip_done(chip_done), .jtag_rdy_n(jtag_rdy_n), .cfg_err_n(cfg_err_n),
    .irq_live(irq_live), .bus_err_pls(bus_err_pls), .irq_ack_pls(irq_ack_pls),
    .cfg_wr(cfg_wr), .status_id(status_id), .gie(gie), .arr_oe_n(arr_oe_n),
    .sup_oe_n(sup_oe_n), .ecl_en(ecl_en), .jtag_en(jtag_en), .jtag_tla(jtag_tla),
    .irq_raise(irq_raise), .cfg_sel(cfg_sel)
  );

  // {write, offset, data}; for reads data is the expected value
  localparam int NV = 18;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 5'd1,  16'hBEEF}, {1'b0, 5'd1,  16'hBEEF},
    {1'b1, 5'd0,  16'h1234}, {1'b0, 5'd0,  16'h0A5C},
    {1'b1, 5'd16, 16'hA5A5}, {1'b1, 5'd31, 16'h5A5A},
    {1'b0, 5'd16, 16'hA5A5}, {1'b0, 5'd31, 16'h5A5A},
    {1'b0, 5'd3,  16'h0000}, {1'b0, 5'd14, 16'h0000},
    {1'b1, 5'd6,  16'hFFFF}, {1'b0, 5'd6,  16'h8001},
    {1'b1, 5'd12, 16'hFFFF}, {1'b0, 5'd12, 16'h0000},
    {1'b0, 5'd15, 16'h0000}, {1'b1, 5'd9,  16'h00F0},
    {1'b0, 5'd9,  16'h00F0}, {1'b0, 5'd7,  16'h0003}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic do_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] e);
    logic [DW-1:0] d;
    do_rd(a, d);
    chk(tag, 32'(d), 32'(e));
  endtask

  task automatic cfg_pulse(input string tag, input logic [31:0] e);
    @(negedge clk); cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
    chk(tag, cfg_sel, e);
    @(negedge clk);
    chk({tag, " one-cycle"}, cfg_sel, 32'h0);
  endtask

  task automatic arm_seq();
    do_wr(5'd2, 16'h007C); do_wr(5'd2, 16'h007D); do_wr(5'd2, 16'h007C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd_chk("R1 csr reset", 5'd2, 16'h0380);
    chk("R1 arr_oe_n", 32'(arr_oe_n), 1); chk("R1 sup_oe_n", 32'(sup_oe_n), 1);
    chk("R1 gie", 32'(gie), 0); chk("R1 status_id", 32'(status_id), 0);
    rd_chk("R1 cen reset", 5'd4, 16'h0000);
    cfg_pulse("R10 unarmed after reset", 32'h0);

    // R2 R3 R4 map vectors
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) do_wr(VEC[i][20:16], VEC[i][15:0]);
      else rd_chk($sformatf("R2 R3 R4 vector %0d", i), VEC[i][20:16], VEC[i][15:0]);
    end
    chk("R3 status_id pin", 32'(status_id), 32'hBEEF);

    // R5 output polarity
    do_wr(5'd2, 16'h037C);
    chk("R5 arr_oe_n", 32'(arr_oe_n), 0); chk("R5 sup_oe_n", 32'(sup_oe_n), 0);
    chk("R5 ecl_en", 32'(ecl_en), 1); chk("R5 jtag_en", 32'(jtag_en), 1);
    chk("R5 jtag_tla", 32'(jtag_tla), 1);

    // R9 live bits and ignored bits
    jtag_rdy_n = 0; cfg_err_n = 0; irq_live = 1;
    do_wr(5'd2, 16'hFF7C);
    rd_chk("R9 live bits", 5'd2, 16'h1B7C);
    jtag_rdy_n = 1; cfg_err_n = 1; irq_live = 0;

    // R6 sticky flags
    do_wr(5'd2, 16'h007C);
    rd_chk("R6 flags cleared", 5'd2, 16'h00FC);
    @(negedge clk); bus_err_pls = 1; @(negedge clk); bus_err_pls = 0;
    rd_chk("R6 error pulse sets", 5'd2, 16'h02FC);
    do_wr(5'd2, 16'h027C);
    rd_chk("R6 write one keeps", 5'd2, 16'h02FC);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = 5'd2; bus_wdata = 16'h007C; bus_err_pls = 1;
    @(negedge clk);
    bus_req = 0; bus_wr = 0; bus_err_pls = 0;
    rd_chk("R6 pulse beats clear", 5'd2, 16'h02FC);
    do_wr(5'd2, 16'h017C);
    rd_chk("R6 reconfig not set by write", 5'd2, 16'h00FC);

    // R8 interrupt request views
    do_wr(5'd9, 16'h0000);
    do_wr(5'd8, 16'h0005);
    chip_stat_n = 32'hFFFF_FFFB;
    rd_chk("R8 req word", 5'd12, 16'h0004);
    rd_chk("R8 bit10 without gie", 5'd2, 16'h04FC);
    chk("R8 no raise without gie", 32'(irq_raise), 0);
    chip_stat_n = 32'hFFFF_FFF9;
    rd_chk("R4 status view", 5'd10, 16'hFFF9);
    rd_chk("R8 disabled chip masked", 5'd12, 16'h0004);

    // R7 / R8 global enable and acknowledge
    do_wr(5'd2, 16'h007E);
    @(negedge clk);
    chk("R7 gie set", 32'(gie), 1);
    chk("R8 raise", 32'(irq_raise), 1);
    @(negedge clk); irq_ack_pls = 1; @(negedge clk); irq_ack_pls = 0;
    chk("R7 ack clears gie", 32'(gie), 0);
    @(negedge clk);
    chk("R8 raise drops", 32'(irq_raise), 0);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = 5'd2; bus_wdata = 16'h007E; irq_ack_pls = 1;
    @(negedge clk);
    bus_req = 0; bus_wr = 0; irq_ack_pls = 0;
    chk("R7 ack beats write", 32'(gie), 0);
    rd_chk("R7 csr after collision", 5'd2, 16'h04FC);
    chip_stat_n = '1;

    // R10 arming
    do_wr(5'd4, 16'h0007);
    do_wr(5'd5, 16'h8000);
    arm_seq();
    cfg_pulse("R10 armed select", 32'h8000_0006);

    // R11 arm drops
    do_wr(5'd2, 16'h007D);
    cfg_pulse("R11 one while armed", 32'h0);
    arm_seq();
    cfg_pulse("R10 rearmed", 32'h8000_0006);
    do_wr(5'd5, 16'h0001);
    cfg_pulse("R11 enable write drops", 32'h0);
    arm_seq();
    do_wr(5'd4, 16'h0000);
    cfg_pulse("R11 zero enable keeps arm", 32'h0001_0000);
    do_wr(5'd2, 16'h007C); do_wr(5'd2, 16'h007D);
    do_wr(5'd2, 16'h007D); do_wr(5'd2, 16'h007C);
    cfg_pulse("R11 out of order", 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule